// File: doc/BRIEF.md
# GPIO Expander Register Core

This block is the register and interrupt core of a 16-pin general-purpose I/O expander. It sits behind a serial-bus slave that decodes bus transactions into a simple parallel register port. The core holds, for each of two 8-bit ports, an output register, a polarity-inversion register, a direction (configuration) register and a latched input register. It drives per-pin output enables and output values, samples the pin levels, and returns polarity-adjusted input data. An active-low interrupt flags any input pin whose level no longer matches its latched value.

An access takes effect only when the bus address presented with it equals the fixed base address with its low bits replaced by the two address-select inputs. This lets four such devices share one bus. A synchronous power-on reset restores every register. The external reset input behaves in one of two ways, chosen at build time. In the full variant it restores every register. In the retain variant it resets only the bus-side logic and leaves the pins driven as they were.

Top module: `gpx_core`

## Requirements
- R1: After power-on reset, all pins are inputs (`pin_oe` all 0), `pin_out` is all 1s, `irq_n` is 1, and `rd_data` is 0. Read-back gives output registers 0xFF, polarity registers 0x00 and configuration registers 0xFF.
- R2: Register index bits [2:1] select the register kind: 0 input, 1 output, 2 polarity, 3 configuration. Bit [0] selects the port, where port 0 is pins 7..0 and port 1 is pins 15..8. A write to a writable register is visible from the next clock edge. `rd_data` shows the addressed value one clock after `rd_en` and holds its value while no read is made.
- R3: A configuration bit of 1 makes its pin an input and a bit of 0 makes it an output, so `pin_oe` is the inverse of the configuration registers. `pin_out` carries the output registers.
- R4: Reading an input port returns the pin levels sampled in the read cycle, each bit inverted where that port's polarity bit is 1.
- R5: Writes to indices 0 and 1 (the input ports) change no register, including the latched input values.
- R6: `irq_n` goes low one clock after an input-configured pin differs from its latched input value. Pins configured as outputs never pull it low.
- R7: Reading an input port reloads that port's latched value from the pins. If that port was the only cause, `irq_n` returns high two clocks after the read strobe. Reading the other port does not clear it.
- R8: A write or read is carried out only when `bus_addr` equals the upper bits of the base address (default 0x74) followed by `addr_sel`. Otherwise no register changes and `rd_data` holds.
- R9: In the full-reset variant, while `ext_rst_n` is low, all registers are held at their R1 defaults, `rd_data` is 0 and accesses are ignored.
- R10: In the retain variant, while `ext_rst_n` is low, the output, polarity and configuration registers and the pins keep their values. Accesses are ignored and `rd_data` is 0.
- R11: Power-on reset restores the R1 defaults in both variants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| por | input | 1 | Synchronous power-on reset, active high |
| ext_rst_n | input | 1 | External reset, active low; effect set by variant |
| addr_sel | input | 2 | Strap inputs forming the low bits of the device address |
| bus_addr | input | 7 | Device address of the current access |
| reg_idx | input | 3 | Register index: kind in [2:1], port in [0] |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 16 | Sampled pin levels |
| pin_oe | output | 16 | Per-pin output enable, 1 drives the pin |
| pin_out | output | 16 | Per-pin output value |
| irq_n | output | 1 | Change interrupt, active low |

## Verification
The change detector is tried with four patterns. A single-bit toggle on port 0 and then on port 1 shows which port holds the pending difference. A toggle that reverts shows that the comparison is live and not sticky. Toggles on output-configured pins must stay silent, which separates the direction mask from the comparison. Polarity is exercised with all-ones and half-ones masks against an asymmetric pin pattern, so a swapped port or swapped nibble shows up. Two builds, one of each reset variant, share every stimulus, so the external reset separates a register reset from a bus-only reset. Mismatched addresses, made both through the bus address and through the strap inputs, confirm that the address is decoded.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int GPX_PORT_W    = 8;
    localparam int GPX_NUM_PORTS = 2;
    localparam int GPX_KIND_W    = 2;

    typedef enum logic [GPX_KIND_W-1:0] {
        KIND_INPUT    = 2'd0,
        KIND_OUTPUT   = 2'd1,
        KIND_POLARITY = 2'd2,
        KIND_CONFIG   = 2'd3
    } reg_kind_e;

    typedef enum logic {
        RST_FULL   = 1'b0,
        RST_RETAIN = 1'b1
    } rst_mode_e;

    // per-port strobes from decode to a register bank
    typedef struct packed {
        logic wr_out;
        logic wr_pol;
        logic wr_cfg;
        logic refresh;
    } bank_strb_t;

    function automatic logic kind_writable(input reg_kind_e k);
        return k != KIND_INPUT;
    endfunction

endpackage

// File: rtl/gpx_bus_ctl.sv
module gpx_bus_ctl
    import gpx_pkg::*;
#(
    parameter int PORT_W     = GPX_PORT_W,
    parameter int NUM_PORTS  = GPX_NUM_PORTS,
    parameter int BUS_ADDR_W = 7,
    parameter int ADDR_SEL_W = 2,
    parameter logic [BUS_ADDR_W-1:0] ADDR_BASE = 7'h74
) (
    input  logic                                  clk,
    input  logic                                  bus_rst,
    input  logic [BUS_ADDR_W-1:0]                 bus_addr,
    input  logic [ADDR_SEL_W-1:0]                 addr_sel,
    input  logic [GPX_KIND_W+$clog2(NUM_PORTS)-1:0] reg_idx,
    input  logic                                  wr_en,
    input  logic                                  rd_en,
    input  logic [PORT_W-1:0]                     in_view [NUM_PORTS],
    input  logic [PORT_W-1:0]                     out_q   [NUM_PORTS],
    input  logic [PORT_W-1:0]                     pol_q   [NUM_PORTS],
    input  logic [PORT_W-1:0]                     cfg_q   [NUM_PORTS],
    output bank_strb_t [NUM_PORTS-1:0]            strb,
    output logic [PORT_W-1:0]                     rd_data
);
    localparam int PSEL_W = $clog2(NUM_PORTS);
    localparam int IDX_W  = GPX_KIND_W + PSEL_W;
    localparam int HI_W   = BUS_ADDR_W - ADDR_SEL_W;

    localparam logic [HI_W-1:0] BASE_HI = ADDR_BASE[BUS_ADDR_W-1:ADDR_SEL_W];

    logic              selected;
    reg_kind_e         kind;
    logic [PSEL_W-1:0] port_sel;
    logic              wr_ok;
    logic              rd_ok;
    logic [PORT_W-1:0] rd_mux;

    assign selected = !bus_rst && (bus_addr == {BASE_HI, addr_sel});
    assign kind     = reg_kind_e'(reg_idx[IDX_W-1 -: GPX_KIND_W]);
    assign port_sel = reg_idx[PSEL_W-1:0];
    assign wr_ok    = selected && wr_en && kind_writable(kind);
    assign rd_ok    = selected && rd_en;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_strb
        logic hit;
        assign hit             = (port_sel == PSEL_W'(p));
        assign strb[p].wr_out  = wr_ok && hit && (kind == KIND_OUTPUT);
        assign strb[p].wr_pol  = wr_ok && hit && (kind == KIND_POLARITY);
        assign strb[p].wr_cfg  = wr_ok && hit && (kind == KIND_CONFIG);
        assign strb[p].refresh = rd_ok && hit && (kind == KIND_INPUT);
    end

    always_comb begin
        case (kind)
            KIND_INPUT:    rd_mux = in_view[port_sel];
            KIND_OUTPUT:   rd_mux = out_q[port_sel];
            KIND_POLARITY: rd_mux = pol_q[port_sel];
            default:       rd_mux = cfg_q[port_sel];
        endcase
    end

    always_ff @(posedge clk) begin
        if (bus_rst) begin
            rd_data <= '0;
        end else if (rd_ok) begin
            rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/gpx_port_bank.sv
module gpx_port_bank
    import gpx_pkg::*;
#(
    parameter int PORT_W = GPX_PORT_W
) (
    input  logic              clk,
    input  logic              regs_rst,
    input  bank_strb_t        strb,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [PORT_W-1:0] pins,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] pol_q,
    output logic [PORT_W-1:0] cfg_q,
    output logic [PORT_W-1:0] latch_q
);

    always_ff @(posedge clk) begin
        if (regs_rst) begin
            out_q <= '1;
            pol_q <= '0;
            cfg_q <= '1;
        end else begin
            if (strb.wr_out) out_q <= wr_data;
            if (strb.wr_pol) pol_q <= wr_data;
            if (strb.wr_cfg) cfg_q <= wr_data;
        end
    end

    // reset and host reads both resynchronise the latched view to the pins
    always_ff @(posedge clk) begin
        if (regs_rst || strb.refresh) begin
            latch_q <= pins;
        end
    end

endmodule

// File: rtl/gpx_change_det.sv
module gpx_change_det #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins,
    input  logic [WIDTH-1:0] latched,
    input  logic [WIDTH-1:0] is_input,
    output logic             irq_n
);
    logic [WIDTH-1:0] diff;

    assign diff = (pins ^ latched) & is_input;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ~|diff;
        end
    end

endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int        PORT_W     = GPX_PORT_W,
    parameter int        NUM_PORTS  = GPX_NUM_PORTS,
    parameter int        BUS_ADDR_W = 7,
    parameter int        ADDR_SEL_W = 2,
    parameter logic [BUS_ADDR_W-1:0] ADDR_BASE = 7'h74,
    parameter rst_mode_e RST_MODE   = RST_FULL
) (
    input  logic                                    clk,
    input  logic                                    por,
    input  logic                                    ext_rst_n,
    input  logic [ADDR_SEL_W-1:0]                   addr_sel,
    input  logic [BUS_ADDR_W-1:0]                   bus_addr,
    input  logic [GPX_KIND_W+$clog2(NUM_PORTS)-1:0] reg_idx,
    input  logic                                    wr_en,
    input  logic [PORT_W-1:0]                       wr_data,
    input  logic                                    rd_en,
    output logic [PORT_W-1:0]                       rd_data,
    input  logic [NUM_PORTS*PORT_W-1:0]             pin_in,
    output logic [NUM_PORTS*PORT_W-1:0]             pin_oe,
    output logic [NUM_PORTS*PORT_W-1:0]             pin_out,
    output logic                                    irq_n
);
    localparam int TOTAL_W = NUM_PORTS * PORT_W;

    logic regs_rst;
    logic bus_rst;

    // the external reset reaches the registers only in the full variant
    if (RST_MODE == RST_FULL) begin : g_rst_full
        assign regs_rst = por || !ext_rst_n;
    end else begin : g_rst_retain
        assign regs_rst = por;
    end
    assign bus_rst = por || !ext_rst_n;

    bank_strb_t [NUM_PORTS-1:0] strb;
    logic [PORT_W-1:0] out_q   [NUM_PORTS];
    logic [PORT_W-1:0] pol_q   [NUM_PORTS];
    logic [PORT_W-1:0] cfg_q   [NUM_PORTS];
    logic [PORT_W-1:0] latch_q [NUM_PORTS];
    logic [PORT_W-1:0] in_view [NUM_PORTS];
    logic [TOTAL_W-1:0] latch_all;
    logic [TOTAL_W-1:0] cfg_all;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [PORT_W-1:0] pins_p;
        assign pins_p = pin_in[p*PORT_W +: PORT_W];

        gpx_port_bank #(
            .PORT_W (PORT_W)
        ) u_bank (
            .clk      (clk),
            .regs_rst (regs_rst),
            .strb     (strb[p]),
            .wr_data  (wr_data),
            .pins     (pins_p),
            .out_q    (out_q[p]),
            .pol_q    (pol_q[p]),
            .cfg_q    (cfg_q[p]),
            .latch_q  (latch_q[p])
        );

        assign in_view[p]                   = pins_p ^ pol_q[p];
        assign latch_all[p*PORT_W +: PORT_W] = latch_q[p];
        assign cfg_all[p*PORT_W +: PORT_W]   = cfg_q[p];
        assign pin_out[p*PORT_W +: PORT_W]   = out_q[p];
    end

    assign pin_oe = ~cfg_all;

    gpx_bus_ctl #(
        .PORT_W     (PORT_W),
        .NUM_PORTS  (NUM_PORTS),
        .BUS_ADDR_W (BUS_ADDR_W),
        .ADDR_SEL_W (ADDR_SEL_W),
        .ADDR_BASE  (ADDR_BASE)
    ) u_bus (
        .clk      (clk),
        .bus_rst  (bus_rst),
        .bus_addr (bus_addr),
        .addr_sel (addr_sel),
        .reg_idx  (reg_idx),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .in_view  (in_view),
        .out_q    (out_q),
        .pol_q    (pol_q),
        .cfg_q    (cfg_q),
        .strb     (strb),
        .rd_data  (rd_data)
    );

    gpx_change_det #(
        .WIDTH (TOTAL_W)
    ) u_irq (
        .clk      (clk),
        .rst      (regs_rst),
        .pins     (pin_in),
        .latched  (latch_all),
        .is_input (cfg_all),
        .irq_n    (irq_n)
    );

endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk
    import gpx_pkg::*;
#(
    parameter int        PORT_W     = GPX_PORT_W,
    parameter int        NUM_PORTS  = GPX_NUM_PORTS,
    parameter int        BUS_ADDR_W = 7,
    parameter int        ADDR_SEL_W = 2,
    parameter logic [BUS_ADDR_W-1:0] ADDR_BASE = 7'h74,
    parameter rst_mode_e RST_MODE   = RST_FULL
) (
    input logic                                    clk,
    input logic                                    por,
    input logic                                    ext_rst_n,
    input logic [ADDR_SEL_W-1:0]                   addr_sel,
    input logic [BUS_ADDR_W-1:0]                   bus_addr,
    input logic [GPX_KIND_W+$clog2(NUM_PORTS)-1:0] reg_idx,
    input logic                                    wr_en,
    input logic [PORT_W-1:0]                       wr_data,
    input logic                                    rd_en,
    input logic [PORT_W-1:0]                       rd_data,
    input logic [NUM_PORTS*PORT_W-1:0]             pin_in,
    input logic [NUM_PORTS*PORT_W-1:0]             pin_oe,
    input logic [NUM_PORTS*PORT_W-1:0]             pin_out,
    input logic                                    irq_n
);
    localparam int PSEL_W = $clog2(NUM_PORTS);
    localparam int IDX_W  = GPX_KIND_W + PSEL_W;

    logic addr_ok;
    logic cfg_write;
    assign addr_ok   = bus_addr == {ADDR_BASE[BUS_ADDR_W-1:ADDR_SEL_W], addr_sel};
    assign cfg_write = wr_en && addr_ok && (reg_idx[IDX_W-1 -: GPX_KIND_W] == KIND_CONFIG);

    assert_reset_defaults_R1: assert property (@(posedge clk)
        por |=> (pin_oe == '0 && irq_n && rd_data == '0));

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (por || !ext_rst_n)
        !(rd_en && addr_ok) |=> $stable(rd_data));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_oe
        assert_cfg_to_oe_R3: assert property (@(posedge clk) disable iff (por || !ext_rst_n)
            (cfg_write && reg_idx[PSEL_W-1:0] == PSEL_W'(p))
            |=> pin_oe[p*PORT_W +: PORT_W] == ~$past(wr_data));
    end

    assert_outputs_quiet_R6: assert property (@(posedge clk) disable iff (por)
        (&pin_oe) |=> irq_n);

    assert_addr_filter_R8: assert property (@(posedge clk) disable iff (por || !ext_rst_n)
        (wr_en && !addr_ok) |=> ($stable(pin_oe) && $stable(pin_out)));

    if (RST_MODE == RST_FULL) begin : g_full
        assert_ext_full_R9: assert property (@(posedge clk) disable iff (por)
            !ext_rst_n |=> (pin_oe == '0 && pin_out == '1 && irq_n && rd_data == '0));
    end else begin : g_retain
        assert_ext_retain_R10: assert property (@(posedge clk) disable iff (por)
            !ext_rst_n |=> ($stable(pin_oe) && $stable(pin_out) && rd_data == '0));
    end

    assert_por_out_R11: assert property (@(posedge clk)
        por |=> pin_out == '1);

endmodule

bind gpx_core gpx_core_chk #(
    .PORT_W     (PORT_W),
    .NUM_PORTS  (NUM_PORTS),
    .BUS_ADDR_W (BUS_ADDR_W),
    .ADDR_SEL_W (ADDR_SEL_W),
    .ADDR_BASE  (ADDR_BASE),
    .RST_MODE   (RST_MODE)
) u_chk (
    .clk       (clk),
    .por       (por),
    .ext_rst_n (ext_rst_n),
    .addr_sel  (addr_sel),
    .bus_addr  (bus_addr),
    .reg_idx   (reg_idx),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .irq_n     (irq_n)
);

// File: tb/test_gpx_core.sv
module test_gpx_core;
    import gpx_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        por, ext_rst_n, wr_en, rd_en;
    logic [1:0]  addr_sel;
    logic [6:0]  bus_addr;
    logic [2:0]  reg_idx;
    logic [7:0]  wr_data;
    logic [15:0] pin_in;
    logic [7:0]  rd_f, rd_r;
    logic [15:0] oe_f, out_f, oe_r, out_r;
    logic        irq_f, irq_r;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [6:0] MY_ADDR = 7'h76;

    gpx_core #(.ADDR_BASE(7'h74), .RST_MODE(RST_FULL)) i_gpx_core (
        .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .addr_sel(addr_sel),
        .bus_addr(bus_addr), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_f), .pin_in(pin_in), .pin_oe(oe_f),
        .pin_out(out_f), .irq_n(irq_f));

    gpx_core #(.ADDR_BASE(7'h74), .RST_MODE(RST_RETAIN)) i_gpx_core_retain (
        .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .addr_sel(addr_sel),
        .bus_addr(bus_addr), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_r), .pin_in(pin_in), .pin_oe(oe_r),
        .pin_out(out_r), .irq_n(irq_r));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [2:0] idx, input logic [7:0] d);
        reg_idx = idx; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] idx);
        reg_idx = idx; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "oe full", 32'(oe_f), 32'h0);
        chk("R11", "oe retain", 32'(oe_r), 32'h0);
        chk("R1", "out", 32'(out_f), 32'hFFFF);
        chk("R1", "irq", 32'(irq_f), 32'h1);
        chk("R1", "rd", 32'(rd_f), 32'h0);
        do_read(3'd2); chk("R1", "out0 rb", 32'(rd_f), 32'hFF);
        do_read(3'd5); chk("R1", "pol1 rb", 32'(rd_f), 32'h00);
        do_read(3'd7); chk("R1", "cfg1 rb", 32'(rd_f), 32'hFF);
    endtask

    task automatic t_regs;
        do_write(3'd6, 8'h0F); chk("R3", "oe after cfg0", 32'(oe_f), 32'h00F0);
        do_write(3'd2, 8'hA5); chk("R3", "out after out0", 32'(out_f), 32'hFFA5);
        do_write(3'd7, 8'h00); chk("R3", "oe after cfg1", 32'(oe_f), 32'hFFF0);
        do_write(3'd3, 8'h5A); chk("R2", "out after out1", 32'(out_f), 32'h5AA5);
        do_read(3'd6); chk("R2", "cfg0 rb", 32'(rd_f), 32'h0F);
        do_read(3'd2); chk("R2", "out0 rb", 32'(rd_f), 32'hA5);
        do_read(3'd3); chk("R2", "out1 rb", 32'(rd_f), 32'h5A);
        cyc(2);        chk("R2", "rd hold", 32'(rd_f), 32'h5A);
        do_write(3'd6, 8'hFF);
        do_write(3'd7, 8'hFF); chk("R3", "oe restored", 32'(oe_f), 32'h0);
    endtask

    task automatic t_polarity;
        pin_in = 16'h3C5A;
        do_write(3'd4, 8'hFF);
        do_read(3'd0); chk("R4", "in0 inv all", 32'(rd_f), 32'hA5);
        do_write(3'd5, 8'h0F);
        do_read(3'd1); chk("R4", "in1 inv low", 32'(rd_f), 32'h33);
        do_write(3'd4, 8'h00);
        do_read(3'd0); chk("R4", "in0 plain", 32'(rd_f), 32'h5A);
        do_write(3'd5, 8'h00);
        do_read(3'd1); chk("R4", "in1 plain", 32'(rd_f), 32'h3C);
        cyc(1);        chk("R7", "irq idle after sync", 32'(irq_f), 32'h1);
    endtask

    task automatic t_irq;
        pin_in = pin_in ^ 16'h0008; cyc(1);
        chk("R6", "irq on pin3", 32'(irq_f), 32'h0);
        pin_in = pin_in ^ 16'h0008; cyc(1);
        chk("R6", "irq after revert", 32'(irq_f), 32'h1);
        pin_in = pin_in ^ 16'h0200; cyc(1);
        chk("R6", "irq on pin9", 32'(irq_f), 32'h0);
        do_read(3'd0); cyc(1);
        chk("R7", "other port read keeps irq", 32'(irq_f), 32'h0);
        do_read(3'd1);
        chk("R7", "in1 value", 32'(rd_f), 32'h3E);
        cyc(1);
        chk("R7", "irq cleared by read", 32'(irq_f), 32'h1);
        do_write(3'd6, 8'hF0);
        pin_in = pin_in ^ 16'h0001; cyc(1);
        chk("R6", "output pin silent", 32'(irq_f), 32'h1);
        pin_in = pin_in ^ 16'h0010; cyc(1);
        chk("R6", "input pin fires", 32'(irq_f), 32'h0);
        pin_in = 16'h3E5A; cyc(1);
        chk("R6", "irq after restore", 32'(irq_f), 32'h1);
        do_write(3'd6, 8'hFF);
    endtask

    task automatic t_idx0;
        pin_in = 16'h3EDA; cyc(1);
        chk("R5", "irq pending", 32'(irq_f), 32'h0);
        do_write(3'd0, 8'hDA);
        do_write(3'd1, 8'h00);
        cyc(1);
        chk("R5", "input writes leave latch", 32'(irq_f), 32'h0);
        do_read(3'd2); chk("R5", "out0 intact", 32'(rd_f), 32'hA5);
        do_read(3'd6); chk("R5", "cfg0 intact", 32'(rd_f), 32'hFF);
        do_read(3'd0); chk("R5", "in0 value", 32'(rd_f), 32'hDA);
        cyc(1);
        chk("R5", "port1 latch intact", 32'(irq_f), 32'h1);
    endtask

    task automatic t_addr;
        bus_addr = 7'h75;
        do_write(3'd2, 8'h00);
        chk("R8", "foreign addr write", 32'(out_f), 32'h5AA5);
        do_read(3'd3);
        chk("R8", "foreign addr read", 32'(rd_f), 32'hDA);
        bus_addr = MY_ADDR; addr_sel = 2'b01;
        do_write(3'd2, 8'h00);
        chk("R8", "strap mismatch write", 32'(out_f), 32'h5AA5);
        addr_sel = 2'b10;
    endtask

    task automatic t_ext;
        do_write(3'd6, 8'h00);
        do_write(3'd2, 8'h3C);
        do_write(3'd5, 8'hFF);
        do_read(3'd2);
        chk("R10", "rd before ext", 32'(rd_r), 32'h3C);
        ext_rst_n = 1'b0; cyc(1);
        chk("R9",  "full oe", 32'(oe_f), 32'h0);
        chk("R9",  "full out", 32'(out_f), 32'hFFFF);
        chk("R9",  "full rd", 32'(rd_f), 32'h0);
        chk("R10", "retain oe", 32'(oe_r), 32'h00FF);
        chk("R10", "retain out", 32'(out_r), 32'h5A3C);
        chk("R10", "retain rd", 32'(rd_r), 32'h0);
        do_write(3'd2, 8'h11);
        chk("R10", "retain write ignored", 32'(out_r), 32'h5A3C);
        chk("R9",  "full write ignored", 32'(out_f), 32'hFFFF);
        ext_rst_n = 1'b1; cyc(1);
        do_read(3'd5);
        chk("R9",  "full pol1", 32'(rd_f), 32'h00);
        chk("R10", "retain pol1", 32'(rd_r), 32'hFF);
        do_read(3'd6);
        chk("R9",  "full cfg0", 32'(rd_f), 32'hFF);
        chk("R10", "retain cfg0", 32'(rd_r), 32'h00);
    endtask

    task automatic t_por;
        por = 1'b1; cyc(2); por = 1'b0;
        chk("R11", "retain oe", 32'(oe_r), 32'h0);
        chk("R11", "retain out", 32'(out_r), 32'hFFFF);
        do_read(3'd5);
        chk("R11", "retain pol1", 32'(rd_r), 32'h00);
    endtask

    initial begin
        por = 1'b1; ext_rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        addr_sel = 2'b10; bus_addr = MY_ADDR; reg_idx = '0; wr_data = '0;
        pin_in = 16'h0000;
        cyc(3);
        por = 1'b0;
        t_reset();
        t_regs();
        t_polarity();
        t_irq();
        t_idx0();
        t_addr();
        t_ext();
        t_por();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule